// File: doc/BRIEF.md
# Page-Mode Parallel Flash Word Streamer

This block reads a run of consecutive words from an asynchronous parallel NOR flash that supports page-mode reads. The host gives a start address, a word count and a first-access wait in cycles, and pulses a start input. The controller then enables the flash, steps the address one word at a time, samples the data bus and hands each word out with a one-cycle valid strobe.

The flash answers the first word of a page slowly and any further word of the same page quickly. The controller follows this. A word that opens a page, or the first word of a transfer wherever it falls, gets the full programmable wait. Every other word gets one clock cycle. A page is `PAGE_WORDS` words long, a power of two, aligned on address multiples of that size. The wait must cover address output delay, the flash access time and input setup. The single-cycle interval must cover the same delays with the page access time in place of the full access time.

Top module: `pflash_page_reader`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, both enables are high (inactive) and `out_valid` and `done` are low. A reset during a transfer abandons it.
- R2: A start accepted in idle with a nonzero count drives `flash_ce_n` and `flash_oe_n` low from the next cycle. They stay low until the last word is sampled and go high on that same edge.
- R3: The first word of a transfer is sampled `W` edges after the start edge, where `W` is `first_wait` captured at start. A later change of `first_wait` has no effect on a running transfer.
- R4: A word whose address has nonzero low log2(`PAGE_WORDS`) bits, other than the first word of a transfer, is sampled one cycle after the previous word.
- R5: A word whose low log2(`PAGE_WORDS`) address bits are all zero waits the full `W` cycles again, counted from the previous sample.
- R6: A transfer starting at an unaligned address uses the full wait for its first word, one cycle per word up to the end of that page, and the full wait at the next page.
- R7: Word i is read from address `start_addr + i`. `flash_addr` holds that value for the whole interval. `out_data` is the bus value at the sampling edge, shown with `out_valid` high for exactly the one cycle after that edge.
- R8: A `first_wait` value of 0 or 1 gives a one-cycle wait, so every word of the transfer takes one cycle.
- R9: `done` is high for exactly one cycle, the cycle after the final word's `out_valid`.
- R10: A start with a word count of zero causes no enable, no valid and no done. A start while a transfer is running is ignored and does not change that transfer's addresses or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a transfer |
| start_addr | input | ADDR_W | Word address of the first word |
| word_count | input | CNT_W | Number of words to read |
| first_wait | input | WAIT_W | Cycles allowed for a page's first access |
| flash_addr | output | ADDR_W | Word address to the flash |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_dq | input | DATA_W | Flash data bus |
| out_valid | output | 1 | One-cycle strobe per sampled word |
| out_data | output | DATA_W | Sampled word |
| done | output | 1 | One-cycle pulse after the final word |

## Verification
Transfers are run with a single aligned page, with several pages crossed, with an unaligned start and with wait settings of 0 and 1. Each transfer's arrival times are compared with a schedule computed from the address bits. This separates a wait applied on page openings only from one applied on every word or on none. It also separates a wait counted from the previous sample from one counted from the start. Data come from a flash model whose value depends on the address, so sampling one cycle early or late, or an address step missed or repeated, gives wrong words. Zero-count starts, starts during a transfer, a wait changed during a transfer and a reset during a transfer check that these inputs have no effect on the outputs.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

  typedef enum logic [0:0] {
    PFR_IDLE = 1'b0,
    PFR_READ = 1'b1
  } pfr_state_e;

  // Wait setting as applied: anything below two becomes a single cycle.
  function automatic int unsigned eff_wait(input int unsigned w);
    return (w < 2) ? 1 : w;
  endfunction

  // True when the word address opens a page of 'words' entries (power of two).
  function automatic logic is_page_head(input logic [31:0] a, input int unsigned words);
    return (a & 32'(words - 1)) == 32'd0;
  endfunction

endpackage

// File: rtl/pfr_addr_seq.sv
module pfr_addr_seq #(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 12,
  parameter int PAGE_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_count,
  input  logic              step,
  output logic [ADDR_W-1:0] addr_q,
  output logic              last_word,
  output logic              next_head
);

  logic [CNT_W-1:0]  left_q;
  logic [ADDR_W-1:0] addr_nx;

  assign addr_nx = addr_q + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (load) begin
      addr_q <= load_addr;
      left_q <= load_count;
    end else if (step) begin
      addr_q <= addr_nx;
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign last_word = (left_q == CNT_W'(1));

  generate
    if (PAGE_WORDS == 1) begin : g_word_pages
      assign next_head = 1'b1;
    end else begin : g_multi_pages
      assign next_head = pfr_pkg::is_page_head(32'(addr_nx), PAGE_WORDS);
    end
  endgenerate

endmodule

// File: rtl/pfr_wait_timer.sv
module pfr_wait_timer #(
  parameter int WAIT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [WAIT_W-1:0] cfg_in,
  input  logic              run,
  input  logic              long_next,
  output logic              expire
);

  logic [WAIT_W-1:0] cfg_q;
  logic [WAIT_W-1:0] left_q;
  logic [WAIT_W-1:0] long_in;
  logic [WAIT_W-1:0] long_held;

  assign long_in   = WAIT_W'(pfr_pkg::eff_wait(32'(cfg_in)));
  assign long_held = WAIT_W'(pfr_pkg::eff_wait(32'(cfg_q)));
  assign expire    = run && (left_q == WAIT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      left_q <= '0;
    end else if (arm) begin
      cfg_q  <= cfg_in;
      left_q <= long_in;
    end else if (run) begin
      if (expire) left_q <= long_next ? long_held : WAIT_W'(1);
      else        left_q <= left_q - WAIT_W'(1);
    end
  end

endmodule

// File: rtl/pfr_out_stage.sv
module pfr_out_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              final_word,
  input  logic [DATA_W-1:0] dq,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              done
);

  logic fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      fin_q     <= 1'b0;
      done      <= 1'b0;
    end else begin
      out_valid <= capture;
      fin_q     <= capture && final_word;
      done      <= fin_q;
      if (capture) out_data <= dq;
    end
  end

endmodule

// File: rtl/pflash_page_reader.sv
module pflash_page_reader #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 12,
  parameter int WAIT_W     = 5,
  parameter int PAGE_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  word_count,
  input  logic [WAIT_W-1:0] first_wait,
  output logic [ADDR_W-1:0] flash_addr,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  input  logic [DATA_W-1:0] flash_dq,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              done
);

  import pfr_pkg::*;

  pfr_state_e state_q;
  logic       go;
  logic       reading;
  logic       word_fire;
  logic       last_word;
  logic       last_fire;
  logic       next_head;

  assign reading   = (state_q == PFR_READ);
  assign go        = (state_q == PFR_IDLE) && start && (word_count != '0);
  assign last_fire = word_fire && last_word;

  always_ff @(posedge clk) begin
    if (rst)            state_q <= PFR_IDLE;
    else if (go)        state_q <= PFR_READ;
    else if (last_fire) state_q <= PFR_IDLE;
  end

  assign flash_ce_n = !reading;
  assign flash_oe_n = !reading;

  pfr_addr_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_WORDS(PAGE_WORDS)
  ) u_addr (
    .clk(clk), .rst(rst), .load(go), .load_addr(start_addr),
    .load_count(word_count), .step(word_fire), .addr_q(flash_addr),
    .last_word(last_word), .next_head(next_head)
  );

  pfr_wait_timer #(.WAIT_W(WAIT_W)) u_wait (
    .clk(clk), .rst(rst), .arm(go), .cfg_in(first_wait), .run(reading),
    .long_next(next_head), .expire(word_fire)
  );

  pfr_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .capture(word_fire), .final_word(last_word),
    .dq(flash_dq), .out_valid(out_valid), .out_data(out_data), .done(done)
  );

endmodule

// File: rtl/pfr_checker.sv
module pfr_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] flash_addr,
  input logic              flash_ce_n,
  input logic              flash_oe_n,
  input logic              out_valid,
  input logic              done,
  input logic              word_fire,
  input logic              last_fire,
  input logic              next_head
);

  AST_FIRE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    word_fire |-> (!flash_ce_n && !flash_oe_n)); // R2

  AST_RELEASE_AT_LAST: assert property (@(posedge clk) disable iff (rst)
    last_fire |=> (flash_ce_n && flash_oe_n)); // R2

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!flash_ce_n && !word_fire) |=> $stable(flash_addr)); // R7

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (word_fire && !last_fire) |=> (flash_addr == ADDR_W'($past(flash_addr) + 1'b1))); // R7

  AST_VALID_AFTER_FIRE: assert property (@(posedge clk) disable iff (rst)
    word_fire |=> out_valid); // R7

  AST_IN_PAGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (word_fire && !last_fire && !next_head) |=> word_fire); // R4

  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

endmodule

bind pflash_page_reader pfr_checker #(.ADDR_W(ADDR_W)) u_pfr_chk (
  .clk(clk), .rst(rst), .flash_addr(flash_addr), .flash_ce_n(flash_ce_n),
  .flash_oe_n(flash_oe_n), .out_valid(out_valid), .done(done),
  .word_fire(word_fire), .last_fire(last_fire), .next_head(next_head)
);

// File: tb/tb_pflash_page_reader.sv
module tb_pflash_page_reader;

  localparam int AW = 16, DW = 16, CW = 12, WW = 5, PW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] word_count = '0;
  logic [WW-1:0] first_wait = '0;
  logic [AW-1:0] flash_addr;
  logic          flash_ce_n, flash_oe_n;
  logic [DW-1:0] flash_dq;
  logic          out_valid, done;
  logic [DW-1:0] out_data;

  int tests = 0;
  int fails = 0;

  always #5 clk = !clk;

  function automatic logic [DW-1:0] model_word(input logic [AW-1:0] a);
    return DW'(a * 16'h9E37) ^ 16'h1F2E;
  endfunction

  assign flash_dq = model_word(flash_addr);

  pflash_page_reader #(
    .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .WAIT_W(WW), .PAGE_WORDS(PW)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .word_count(word_count), .first_wait(first_wait), .flash_addr(flash_addr),
    .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_dq(flash_dq),
    .out_valid(out_valid), .out_data(out_data), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One transfer; 'poke' issues a stray start mid-way, the wait input is
  // changed after start to show it was captured.
  task automatic run_xfer(input logic [AW-1:0] a, input int cnt, input int w,
                          input bit poke, input string req);
    int eff = (w < 2) ? 1 : w;
    int idx = 0, t_next = eff, t_last = -10;
    int bad_t = 0, bad_d = 0, bad_a = 0, bad_e = 0, bad_n = 0;
    int ta = 0, te = 0, da = 0, de = 0, aa = 0, ae = 0;
    logic [AW-1:0] cur;
    @(negedge clk);
    start = 1'b1; start_addr = a; word_count = CW'(cnt); first_wait = WW'(w);
    @(negedge clk);
    start = 1'b0; first_wait = WW'(9); start_addr = 16'h7000;
    check(!flash_ce_n && !flash_oe_n && flash_addr == a, req, "enables low and address loaded after start",
          {flash_ce_n, flash_oe_n}, 0);
    for (int c = 1; c < 4000; c++) begin
      @(negedge clk);
      if (poke && c == 2) begin start = 1'b1; word_count = CW'(3); end
      if (poke && c == 3) start = 1'b0;
      if (out_valid !== (idx < cnt && c == t_next)) begin
        if (bad_t == 0) begin ta = c; te = t_next; end
        bad_t++;
      end
      if (idx < cnt && c == t_next) begin
        cur = a + AW'(idx);
        if (out_data !== model_word(cur)) begin
          if (bad_d == 0) begin da = int'(out_data); de = int'(model_word(cur)); end
          bad_d++;
        end
        idx++;
        if (idx == cnt) t_last = c;
        else t_next = c + ((((a + AW'(idx)) & AW'(PW - 1)) == 0) ? eff : 1);
      end
      if (idx < cnt && flash_addr !== a + AW'(idx)) begin
        if (bad_a == 0) begin aa = int'(flash_addr); ae = int'(a + AW'(idx)); end
        bad_a++;
      end
      if ((flash_ce_n || flash_oe_n) !== (idx >= cnt) || flash_ce_n !== flash_oe_n) bad_e++;
      if (done !== (c == t_last + 1)) bad_n++;
      if (idx >= cnt && c == t_last + 2) break;
    end
    check(bad_t == 0, req, "word arrival cycle (R3/R4/R5 schedule)", ta, te);
    check(bad_d == 0, "R7", {req, " sampled data"}, da, de);
    check(bad_a == 0, "R7", {req, " flash address per word"}, aa, ae);
    check(bad_e == 0, "R2", {req, " enables low only while words remain"}, bad_e, 0);
    check(bad_n == 0 && idx == cnt, "R9", {req, " single done after last word"}, bad_n, 0);
  endtask

  task automatic t_reset_state;
    check(flash_ce_n && flash_oe_n, "R1", "enables inactive in reset", {flash_ce_n, flash_oe_n}, 3);
    check(!out_valid && !done, "R1", "no valid or done in reset", {out_valid, done}, 0);
  endtask

  task automatic t_zero_count;
    int seen = 0;
    @(negedge clk);
    start = 1'b1; start_addr = 16'h0100; word_count = '0; first_wait = WW'(3);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 8; c++) begin
      if (!flash_ce_n || !flash_oe_n || out_valid || done) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R10", "zero-count start leaves block idle", seen, 0);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    start = 1'b1; start_addr = 16'h0200; word_count = CW'(20); first_wait = WW'(2);
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(flash_ce_n && flash_oe_n && !out_valid && !done, "R1", "reset abandons transfer",
          {flash_ce_n, flash_oe_n, out_valid, done}, 12);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check(flash_ce_n && !out_valid && !done, "R1", "stays idle after mid-transfer reset",
          {flash_ce_n, out_valid, done}, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    run_xfer(16'h0010, 8, 4, 1'b0, "R3");   // aligned single page
    run_xfer(16'h0020, 20, 3, 1'b0, "R5");  // three page openings
    run_xfer(16'h0035, 6, 5, 1'b0, "R6");   // unaligned start
    run_xfer(16'h0040, 10, 0, 1'b0, "R8");  // wait 0 behaves as 1
    run_xfer(16'h0050, 10, 1, 1'b0, "R8");  // wait 1
    run_xfer(16'h0063, 7, 6, 1'b0, "R4");   // in-page single cycles
    run_xfer(16'h0080, 12, 4, 1'b1, "R10"); // stray start ignored
    t_zero_count();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule